// File: doc/BRIEF.md
# Windowed Stack Pointer Engine

This block owns a 16-bit stack pointer whose value is always kept inside a fixed 1 KB on-chip RAM window spanning 0FB00H to 0FEFFH. Whatever value software loads, and whatever a push or pop produces, only the low 10 bits count, and the result is remapped into that window. Decrementing below the bottom of the window wraps to its top, and incrementing past the top wraps to its bottom.

A requester names a frame type and a direction. The engine then moves the frame one byte per clock over a single-port byte memory interface. A push decrements the pointer before each write. A pop reads at the pointer and increments it afterwards. Three frame types exist: a register pair, a program counter (both two bytes) and an interrupt frame (status byte plus program counter, three bytes). When the frame ends, a one-cycle done pulse is raised, and restored bytes are presented on a parallel output.

The pointer holds no defined value after reset. Stack requests are refused until software has loaded it once.

Top module: `stk_ptr_engine`

## Requirements
- R1: A load takes the low 10 bits v of `sp_val_i`. When v is in 0x300..0x3FF, `sp_o` becomes 0xF800+v; otherwise it becomes 0xFC00+v. Examples: loading 0xFF00 gives 0xFB00, and loading 0x1234 gives 0xFE34.
- R2: Until the first accepted load after reset, stack requests are ignored: `busy_o` stays 0 and `mem_we_o` stays 0.
- R3: A push performs each byte write at the folded value of SP−1 and leaves SP equal to that address. A push from 0xFB00 writes its first byte at 0xFEFF.
- R4: A pop reads each byte at SP and then sets SP to the folded value of SP+1. A pop at 0xFEFF is followed by SP = 0xFB00.
- R5: Frame code 2'b00 (register pair) has two bytes. On push, `push_data_i[15:8]` goes to SP−1 and `push_data_i[7:0]` goes to SP−2. A pop returns them on `pop_data_o[15:0]` with bits 23:16 at zero.
- R6: Frame code 2'b01 (program counter) uses the same two-byte layout. The high byte goes to SP−1 and the low byte to SP−2, and a pop restores them in reverse order.
- R7: Frame code 2'b10 (interrupt) has three bytes. `push_data_i[23:16]` (status) goes to SP−1, `[15:8]` to SP−2 and `[7:0]` to SP−3. A pop returns all 24 bits.
- R8: Frame code 2'b11 is reserved. A request carrying it is ignored, and SP is unchanged.
- R9: One byte moves per clock. `busy_o` is high for exactly as many cycles as the frame has bytes, starting the cycle after acceptance. `done_o` pulses for one cycle as `busy_o` falls. `pop_data_o` is cleared on acceptance and is complete when `done_o` is high.
- R10: Loads and requests that arrive while `busy_o` is high are ignored.
- R11: A load and a request in the same idle cycle apply the load and drop the request.
- R12: `pop_i` = 0 selects push and `pop_i` = 1 selects pop. `mem_we_o` is high only during the byte cycles of a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_ld_i | input | 1 | Load stack pointer |
| sp_val_i | input | 16 | Value to load |
| req_i | input | 1 | Frame request |
| pop_i | input | 1 | 0 push, 1 pop |
| frame_i | input | 2 | Frame type code |
| push_data_i | input | 24 | Frame contents to push |
| pop_data_o | output | 24 | Restored frame contents |
| done_o | output | 1 | Frame finished pulse |
| busy_o | output | 1 | Frame in progress |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read byte (combinational) |

## Verification
Some properties are checked by assertions on every cycle:
- Once loaded, the pointer never leaves the window.
- Each written byte lands at the pointer's new value.
- Each read is followed by the wrapped increment.
- Writes occur only while busy.
- `done_o` pulses once as `busy_o` falls.

Other behaviour can only be shown by the bench scenarios. These cover:
- The byte order within each frame type.
- Restoration of pushed frames in reverse order.
- Refusal of requests before the first load.
- Rejection of the reserved code.
- Loads dropped while busy.
- The priority of a load over a request in the same cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    FR_PAIR = 2'b00,
    FR_PC   = 2'b01,
    FR_INT  = 2'b10,
    FR_RSV  = 2'b11
  } frame_e;

  function automatic logic [1:0] frame_len(frame_e f);
    return (f == FR_INT) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/stk_fold.sv
module stk_fold #(
  parameter int SP_W = 16,
  parameter int OFS_W = 10,
  parameter logic [OFS_W-1:0] SPLIT = 10'h300,
  parameter logic [SP_W-1:0] BASE_LO = 16'hF800,
  parameter logic [SP_W-1:0] BASE_HI = 16'hFC00
) (
  input  logic [SP_W-1:0] raw_i,
  output logic [SP_W-1:0] fold_o
);
  logic [OFS_W-1:0] ofs;
  logic unused_hi;

  assign ofs       = raw_i[OFS_W-1:0];
  assign unused_hi = ^raw_i[SP_W-1:OFS_W];
  // upper quarter of the offset space sits below the rest of the window
  assign fold_o    = ((ofs >= SPLIT) ? BASE_LO : BASE_HI) | SP_W'(ofs);
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] rev_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] idx_q, len_q;
  logic             last;

  assign last = (idx_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else begin
      done_q <= busy_q && last;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        len_q  <= len_i;
      end else if (busy_q) begin
        idx_q <= idx_q + CNT_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign rev_o  = len_q - idx_q - CNT_W'(1);
endmodule

// File: rtl/stk_ptr_engine.sv
module stk_ptr_engine
  import stk_pkg::*;
#(
  parameter int SP_W = 16,
  parameter int OFS_W = 10,
  parameter int BYTE_W = 8,
  parameter int MAX_B = 3,
  parameter logic [OFS_W-1:0] SPLIT = 10'h300,
  parameter logic [SP_W-1:0] BASE_LO = 16'hF800,
  parameter logic [SP_W-1:0] BASE_HI = 16'hFC00
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sp_ld_i,
  input  logic [SP_W-1:0]         sp_val_i,
  input  logic                    req_i,
  input  logic                    pop_i,
  input  logic [1:0]              frame_i,
  input  logic [BYTE_W*MAX_B-1:0] push_data_i,
  output logic [BYTE_W*MAX_B-1:0] pop_data_o,
  output logic                    done_o,
  output logic                    busy_o,
  output logic [SP_W-1:0]         sp_o,
  output logic [SP_W-1:0]         mem_addr_o,
  output logic [BYTE_W-1:0]       mem_wdata_o,
  output logic                    mem_we_o,
  input  logic [BYTE_W-1:0]       mem_rdata_i
);
  localparam int FRM_W = BYTE_W * MAX_B;
  localparam int CNT_W = $clog2(MAX_B + 1);
  localparam int N_FOLD = 3;  // 0: load, 1: decrement, 2: increment

  frame_e           fr;
  logic             busy, ld_ok, start;
  logic [CNT_W-1:0] idx, rev;
  logic [SP_W-1:0]  sp_q;
  logic             sp_vld_q, pop_q;
  logic [FRM_W-1:0] wbuf_q, rbuf_q;
  logic [SP_W-1:0]  raw [N_FOLD];
  logic [SP_W-1:0]  fold [N_FOLD];

  assign fr    = frame_e'(frame_i);
  assign ld_ok = sp_ld_i && !busy;
  assign start = req_i && !busy && !sp_ld_i && sp_vld_q && (fr != FR_RSV);

  assign raw[0] = sp_val_i;
  assign raw[1] = sp_q - SP_W'(1);
  assign raw[2] = sp_q + SP_W'(1);

  for (genvar g = 0; g < N_FOLD; g++) begin : g_fold
    stk_fold #(
      .SP_W(SP_W), .OFS_W(OFS_W), .SPLIT(SPLIT),
      .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
    ) i_fold (
      .raw_i (raw[g]),
      .fold_o(fold[g])
    );
  end

  stk_seq #(.CNT_W(CNT_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .len_i  (CNT_W'(frame_len(fr))),
    .busy_o (busy),
    .done_o (done_o),
    .idx_o  (idx),
    .rev_o  (rev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q     <= BASE_LO | SP_W'(SPLIT);
      sp_vld_q <= 1'b0;
      pop_q    <= 1'b0;
      wbuf_q   <= '0;
      rbuf_q   <= '0;
    end else if (ld_ok) begin
      sp_q     <= fold[0];
      sp_vld_q <= 1'b1;
    end else if (start) begin
      pop_q  <= pop_i;
      wbuf_q <= push_data_i;
      rbuf_q <= '0;
    end else if (busy) begin
      sp_q <= pop_q ? fold[2] : fold[1];
      if (pop_q) rbuf_q[int'(idx)*BYTE_W +: BYTE_W] <= mem_rdata_i;
    end
  end

  // push: most significant byte first, at the highest address
  assign mem_we_o    = busy && !pop_q;
  assign mem_addr_o  = mem_we_o ? fold[1] : sp_q;
  assign mem_wdata_o = wbuf_q[int'(rev)*BYTE_W +: BYTE_W];
  assign pop_data_o  = rbuf_q;
  assign busy_o      = busy;
  assign sp_o        = sp_q;
endmodule

// File: rtl/stk_ptr_chk.sv
module stk_ptr_chk #(
  parameter int SP_W = 16,
  parameter logic [SP_W-1:0] WIN_BOT = 16'hFB00,
  parameter logic [SP_W-1:0] WIN_TOP = 16'hFEFF
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sp_ld_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [SP_W-1:0] sp_o,
  input logic [SP_W-1:0] mem_addr_o,
  input logic            mem_we_o
);
  logic seen_ld;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_ld <= 1'b0;
    else if (sp_ld_i && !busy_o) seen_ld <= 1'b1;

  assert_sp_in_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_ld |-> (sp_o >= WIN_BOT && sp_o <= WIN_TOP));

  assert_idle_before_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_ld |-> (!busy_o && !mem_we_o));

  assert_write_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= WIN_BOT && mem_addr_o <= WIN_TOP));

  assert_predec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(mem_addr_o));

  assert_postinc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o) |=>
      sp_o == (($past(mem_addr_o) == WIN_TOP) ? WIN_BOT : $past(mem_addr_o) + SP_W'(1)));

  assert_we_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_done_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind stk_ptr_engine stk_ptr_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sp_ld_i   (sp_ld_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sp_o      (sp_o),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/test_stk_ptr_engine.sv
module test_stk_ptr_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld, req, pop;
  logic [15:0] val;
  logic [1:0]  frame;
  logic [23:0] data;
  logic [23:0] rdata;
  logic        done, busy, we;
  logic [15:0] sp, addr;
  logic [7:0]  wdata, rbyte;
  logic [7:0]  ram [0:65535];

  always #5 clk = ~clk;

  stk_ptr_engine i_stk_ptr_engine (
    .clk_i(clk), .rst_ni(rst_n), .sp_ld_i(ld), .sp_val_i(val),
    .req_i(req), .pop_i(pop), .frame_i(frame), .push_data_i(data),
    .pop_data_o(rdata), .done_o(done), .busy_o(busy), .sp_o(sp),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rbyte)
  );

  assign rbyte = ram[addr];
  always @(posedge clk) if (we) ram[addr] <= wdata;

  int total = 0, bad = 0, cyc = 0;
  bit fin = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int wfold(int a);
    return 'hFB00 + ((((a - 'hFB00) % 1024) + 1024) % 1024);
  endfunction

  // reference model
  typedef struct { bit is_pop; int bval; int slot; } step_t;
  step_t q[$];
  int  m_sp, m_rd;
  bit  m_ld, m_done;
  int  shadow [int];

  always @(posedge clk or negedge rst_n) begin
    step_t s;
    int n;
    if (!rst_n) begin
      q.delete(); m_ld = 0; m_done = 0; m_rd = 0; m_sp = 0;
    end else if (q.size() > 0) begin
      s = q.pop_front();
      if (!s.is_pop) begin
        m_sp = wfold(m_sp - 1);
        shadow[m_sp] = s.bval;
      end else begin
        m_rd = m_rd | ((shadow.exists(m_sp) ? shadow[m_sp] : 0) << (8 * s.slot));
        m_sp = wfold(m_sp + 1);
      end
      m_done = (q.size() == 0);
    end else begin
      m_done = 0;
      if (ld) begin
        m_sp = wfold(int'(val)); m_ld = 1;
      end else if (req && m_ld && frame != 2'b11) begin
        n = (frame == 2'b10) ? 3 : 2;
        m_rd = 0;
        for (int k = 0; k < n; k++) begin
          if (!pop) q.push_back('{0, (int'(data) >> (8 * (n - 1 - k))) & 255, 0});
          else      q.push_back('{1, 0, k});
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R9 busy", busy, q.size() > 0);
      chk("R9 done", done, m_done);
      chk("R9 rdata", rdata, m_rd);
      if (m_ld) chk("R1 sp", sp, m_sp);
      chk("R12 we", we, (q.size() > 0) && !q[0].is_pop);
      if (q.size() > 0) begin
        if (q[0].is_pop) chk("R4 addr", addr, m_sp);
        else begin
          chk("R3 addr", addr, wfold(m_sp - 1));
          chk("R3 wdata", wdata, q[0].bval);
        end
      end
    end
  end

  task automatic do_frame(bit p, logic [1:0] f, logic [23:0] d);
    @(negedge clk); req = 1; pop = p; frame = f; data = d;
    @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] v);
    @(negedge clk); ld = 1; val = v;
    @(negedge clk); ld = 0;
  endtask

  task automatic finish_run();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 65536; i++) ram[i] = 8'h00;
    rst_n = 0; ld = 0; req = 0; pop = 0; val = '0; frame = '0; data = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R12 reset we", we, 0);
    rst_n = 1;

    // R2: request before any load
    @(negedge clk); req = 1; pop = 0; frame = 2'b00; data = 24'h00_1111;
    @(negedge clk); req = 0;
    chk("R2 busy", busy, 0);
    chk("R2 we", we, 0);

    // R1: SFR-area value folds down
    do_load(16'hFF00);
    chk("R1 fold FF00", sp, 16'hFB00);

    // R3 wrap at bottom, R5 pair, R6 pc, R7 interrupt
    do_frame(0, 2'b00, 24'h00_A55A);
    chk("R3 wrap push", sp, 16'hFEFE);
    chk("R5 hi byte", ram[16'hFEFF], 8'hA5);
    chk("R5 lo byte", ram[16'hFEFE], 8'h5A);
    do_frame(0, 2'b01, 24'h00_1234);
    chk("R6 pc hi", ram[16'hFEFD], 8'h12);
    do_frame(0, 2'b10, 24'h5C_BEEF);
    chk("R7 psw", ram[16'hFEFB], 8'h5C);
    chk("R7 pcl", ram[16'hFEF9], 8'hEF);
    chk("R7 sp", sp, 16'hFEF9);

    do_frame(1, 2'b10, 24'h0);
    chk("R7 pop", rdata, 24'h5C_BEEF);
    do_frame(1, 2'b01, 24'h0);
    chk("R6 pop", rdata, 24'h00_1234);
    do_frame(1, 2'b00, 24'h0);
    chk("R5 pop", rdata, 24'h00_A55A);
    chk("R4 wrap pop", sp, 16'hFB00);

    // R8: reserved code
    @(negedge clk); req = 1; pop = 0; frame = 2'b11; data = 24'h777777;
    @(negedge clk); req = 0;
    chk("R8 busy", busy, 0);
    chk("R8 sp", sp, 16'hFB00);

    do_load(16'h1234);
    chk("R1 fold 1234", sp, 16'hFE34);
    do_load(16'h0000);
    chk("R1 fold 0000", sp, 16'hFC00);
    do_load(16'h1234);

    // R10: load and request during busy ignored
    @(negedge clk); req = 1; pop = 0; frame = 2'b10; data = 24'h010203;
    @(negedge clk); req = 1; ld = 1; val = 16'h0100; frame = 2'b00;
    @(negedge clk); req = 0; ld = 0;
    repeat (4) @(negedge clk);
    chk("R10 sp", sp, 16'hFE31);
    chk("R10 idle", busy, 0);

    // R11: load wins over simultaneous request
    @(negedge clk); ld = 1; val = 16'hFD00; req = 1; pop = 0; frame = 2'b00;
    @(negedge clk); ld = 0; req = 0;
    chk("R11 busy", busy, 0);
    chk("R11 sp", sp, 16'hFD00);

    // stack across the window bottom
    do_load(16'hFB01);
    for (int i = 0; i < 4; i++)
      do_frame(0, 2'(i % 3), 24'(32'h00C0_0F11 * (i + 1)));
    for (int i = 3; i >= 0; i--) begin
      do_frame(1, 2'(i % 3), 24'h0);
      chk("R12 restore", rdata, (i % 3 == 2) ? 24'(32'h00C0_0F11 * (i + 1))
                                              : 24'(32'h0000_0F11 * (i + 1)) & 24'h00FFFF);
    end
    chk("R4 sp back", sp, 16'hFB01);

    finish_run();
  end
endmodule